// File: doc/BRIEF.md
# Edge-Triggered Event Line Controller

This block watches a bank of up to 32 asynchronous event lines and turns them into one active-high interrupt level per line. Each input is first brought into the clock domain, then its rising and falling transitions are caught separately. Software picks, line by line, which transitions count. A caught transition is held in one of two pending registers, one for rising events and one for falling events, until software clears it. A mask register decides which lines may drive their outputs.

Each line is built in one of two forms, chosen when the block is instantiated and readable through a read-only capability register. A configurable line has the full select, pending and software-trigger logic. A direct line has none of that: its synchronised input level goes straight to its output, gated only by the mask.

Software reaches the registers through a plain single-cycle write strobe and a combinational read path. Acknowledging a configurable line means writing a one-hot value to both pending registers. Retriggering a line means writing a one-hot value to the software-trigger register.

Top module: `evline_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the capability register, and every interrupt output is low.
- R2: On a configurable line whose rising-select bit (offset 0x00, bit = line number) is set, a 0-to-1 input change latches bit `line` of the rising-pending register (offset 0x0C). The bit reads 1 after the third clock edge that follows the change, and not before. With the select bit clear, the change latches nothing.
- R3: On a configurable line whose falling-select bit (offset 0x04) is set, a 1-to-0 input change latches the line's bit in the falling-pending register (offset 0x10), with the same three-edge latency. With the select bit clear, nothing is latched. Rising and falling events never set each other's register.
- R4: Writing to a pending register clears exactly the bits written as 1. Bits written as 0 keep their value, and the other pending register is left as it is.
- R5: When a new event and a write-1 clear reach the same pending bit on the same clock edge, the bit stays set.
- R6: Writing 1s to the software-trigger register (offset 0x08) sets the rising-pending bits of those configurable lines on that write's clock edge. Reading offset 0x08 returns the OR of the two pending registers.
- R7: A configurable line's output is high exactly while its mask bit is set and its bit is set in either pending register.
- R8: The capability register (offset 0x84) reads back the build-time line form: 1 for configurable, 0 for direct. Writes to it have no effect.
- R9: On a direct line, the select, pending and software-trigger bits read 0 and writes to them are ignored. Its output equals the mask bit ANDed with the input level, and it follows an input change after the second clock edge.
- R10: The mask register (offset 0x80, bit = line number) is all zeros after reset, is read/write, and while a line's mask bit is 0 its output stays low even if that line is pending.
- R11: Reads from any offset other than the seven listed return 0. Bits above the line count read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Asynchronous event inputs, one per line |
| bus_wr | input | 1 | Register write strobe, acts on the rising clock edge |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | NUM_LINES | Active-high interrupt level per line |

## Verification
The bench builds the block with eight lines and the capability pattern 0x3F, so lines 0 to 5 are configurable and lines 6 and 7 are direct. With this small size, every line can be driven through all four select combinations (none, rising, falling, both) over a full rise-and-fall cycle. Each of these runs checks both pending registers and the outputs against values computed from the line index and the mode bits. Having both line forms in one build lets the bench compare the three-edge latched path with the two-edge pass-through path, and confirm that direct lines ignore writes. Separate directed cases cover a clear that lands on the same edge as a new event, partial clears, and software triggers with the mask set and with it clear.

// File: rtl/evline_pkg.sv
package evline_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;

    // register byte offsets
    localparam addr_t OFS_RSEL   = 8'h00;
    localparam addr_t OFS_FSEL   = 8'h04;
    localparam addr_t OFS_SWTRIG = 8'h08;
    localparam addr_t OFS_RPEND  = 8'h0C;
    localparam addr_t OFS_FPEND  = 8'h10;
    localparam addr_t OFS_MASK   = 8'h80;
    localparam addr_t OFS_CAPS   = 8'h84;

endpackage

// File: rtl/evline_sync.sv
module evline_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/evline_edge.sv
module evline_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/evline_regs.sv
module evline_regs
    import evline_pkg::*;
#(
    parameter int unsigned          NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0] CAP_MASK  = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  addr_t                bus_addr,
    input  word_t                bus_wdata,
    output word_t                bus_rdata,
    input  logic [NUM_LINES-1:0] rise_evt,
    input  logic [NUM_LINES-1:0] fall_evt,
    output logic [NUM_LINES-1:0] pend_rise,
    output logic [NUM_LINES-1:0] pend_fall,
    output logic [NUM_LINES-1:0] mask_o
);

    typedef logic [NUM_LINES-1:0] vec_t;

    typedef struct packed {
        vec_t rsel;
        vec_t fsel;
        vec_t rpend;
        vec_t fpend;
        vec_t mask;
    } state_t;

    localparam vec_t CFG = CAP_MASK;

    state_t st_d, st_q;
    vec_t   wvec;
    vec_t   clr_r, clr_f, sw_set;
    vec_t   rd_vec;

    always_comb begin
        wvec   = bus_wdata[NUM_LINES-1:0];
        st_d   = st_q;
        clr_r  = (bus_wr && bus_addr == OFS_RPEND)  ? wvec : '0;
        clr_f  = (bus_wr && bus_addr == OFS_FPEND)  ? wvec : '0;
        sw_set = (bus_wr && bus_addr == OFS_SWTRIG) ? wvec : '0;

        if (bus_wr && bus_addr == OFS_RSEL) st_d.rsel = wvec & CFG;
        if (bus_wr && bus_addr == OFS_FSEL) st_d.fsel = wvec & CFG;
        if (bus_wr && bus_addr == OFS_MASK) st_d.mask = wvec;

        // new events win over a clear on the same edge
        st_d.rpend = ((st_q.rpend & ~clr_r) | (rise_evt & st_q.rsel) | sw_set) & CFG;
        st_d.fpend = ((st_q.fpend & ~clr_f) | (fall_evt & st_q.fsel)) & CFG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_RSEL:   rd_vec = st_q.rsel;
            OFS_FSEL:   rd_vec = st_q.fsel;
            OFS_SWTRIG: rd_vec = st_q.rpend | st_q.fpend;
            OFS_RPEND:  rd_vec = st_q.rpend;
            OFS_FPEND:  rd_vec = st_q.fpend;
            OFS_MASK:   rd_vec = st_q.mask;
            OFS_CAPS:   rd_vec = CFG;
            default:    rd_vec = '0;
        endcase
        bus_rdata = word_t'(rd_vec);
    end

    assign pend_rise = st_q.rpend;
    assign pend_fall = st_q.fpend;
    assign mask_o    = st_q.mask;

endmodule

// File: rtl/evline_ctrl.sv
module evline_ctrl #(
    parameter int unsigned          NUM_LINES   = 32,
    parameter logic [NUM_LINES-1:0] CAP_MASK    = '1,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_o
);

    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] rise_evt, fall_evt;
    logic [NUM_LINES-1:0] pend_rise, pend_fall, mask_q;

    evline_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    evline_edge #(
        .WIDTH (NUM_LINES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (line_sync),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt)
    );

    evline_regs #(
        .NUM_LINES (NUM_LINES),
        .CAP_MASK  (CAP_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .pend_rise (pend_rise),
        .pend_fall (pend_fall),
        .mask_o    (mask_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (CAP_MASK[i]) begin : g_cfg
            assign irq_o[i] = mask_q[i] & (pend_rise[i] | pend_fall[i]);
        end else begin : g_dir
            assign irq_o[i] = mask_q[i] & line_sync[i];
        end
    end

endmodule

// File: rtl/evline_ctrl_chk.sv
module evline_ctrl_chk
    import evline_pkg::*;
#(
    parameter int unsigned          NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0] CAP_MASK  = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] rpend,
    input logic [NUM_LINES-1:0] fpend,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] irq
);

    logic [NUM_LINES-1:0] clr_r, clr_f, sw_bits;

    assign clr_r   = (bus_wr && bus_addr == OFS_RPEND) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign clr_f   = (bus_wr && bus_addr == OFS_FPEND) ? bus_wdata[NUM_LINES-1:0] : '0;
    assign sw_bits = bus_wdata[NUM_LINES-1:0] & CAP_MASK;

    // R7 / R10: no output rises on a masked line
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~mask) == '0);

    // R9: direct lines never hold pending state
    p_direct_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rpend | fpend) & ~CAP_MASK) == '0);

    // R4: a rising-pending bit drops only under a write-1 clear
    p_rhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rpend) & ~$past(clr_r) & ~rpend) == '0);

    // R4: a falling-pending bit drops only under a write-1 clear
    p_fhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fpend) & ~$past(clr_f) & ~fpend) == '0);

    // R6: software trigger sets rising pending on the next edge
    p_swtrig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SWTRIG) |=> ((rpend & $past(sw_bits)) == $past(sw_bits)));

endmodule

bind evline_ctrl evline_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .CAP_MASK  (CAP_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rpend     (pend_rise),
    .fpend     (pend_fall),
    .mask      (mask_q),
    .irq       (irq_o)
);

// File: tb/evline_ctrl_test.sv
`timescale 1ns/1ps
module evline_ctrl_test;

    localparam int         NL  = 8;
    localparam logic [7:0] CAP = 8'h3F;

    localparam logic [7:0] A_RSEL = 8'h00, A_FSEL = 8'h04, A_SW = 8'h08,
                           A_RP = 8'h0C, A_FP = 8'h10, A_MASK = 8'h80, A_CAP = 8'h84;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lines = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    evline_ctrl #(.NUM_LINES(NL), .CAP_MASK(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_wr(bus_wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #0.5;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rdchk("R1 rsel", A_RSEL, 0);
        rdchk("R1 fsel", A_FSEL, 0);
        rdchk("R1 rpend", A_RP, 0);
        rdchk("R1 fpend", A_FP, 0);
        rdchk("R1 swtrig", A_SW, 0);
        rdchk("R10 mask reset", A_MASK, 0);
        check("R1 irq", 32'(irq), 0);

        // R10 masked pending stays silent, R7 unmasking drives it
        wr(A_SW, 32'h1);
        rdchk("R6 sw sets rpend", A_RP, 32'h1);
        check("R10 masked irq", 32'(irq), 0);
        wr(A_MASK, 32'hFF);
        rdchk("R10 mask rw", A_MASK, 32'hFF);
        check("R7 irq unmasked", 32'(irq), 32'h1);
        wr(A_RP, 32'h1);
        check("R7 irq after clear", 32'(irq), 0);

        // R8 capability register
        rdchk("R8 caps", A_CAP, 32'(CAP));
        wr(A_CAP, 32'h0);
        rdchk("R8 caps after write", A_CAP, 32'(CAP));

        // R11 unmapped offsets
        rdchk("R11 unmapped 0x40", 8'h40, 0);
        rdchk("R11 unmapped 0x14", 8'h14, 0);

        // R9 direct lines ignore select/pending/trigger writes
        wr(A_RSEL, 32'hFFFF_FFFF);
        rdchk("R9 rsel direct zero", A_RSEL, 32'(CAP));
        wr(A_FSEL, 32'hFFFF_FFFF);
        rdchk("R9 fsel direct zero", A_FSEL, 32'(CAP));
        wr(A_RSEL, 0);
        wr(A_FSEL, 0);
        wr(A_SW, 32'hFF);
        rdchk("R9 sw direct zero", A_RP, 32'(CAP));
        wr(A_RP, 32'hFF);
        rdchk("R4 clear all", A_RP, 0);

        // R4 partial clear
        wr(A_SW, 32'h07);
        wr(A_RP, 32'h02);
        rdchk("R4 partial clear", A_RP, 32'h05);
        wr(A_RP, 32'h00);
        rdchk("R4 zero write keeps", A_RP, 32'h05);
        rdchk("R4 other reg untouched", A_FP, 0);
        wr(A_RP, 32'h05);

        // R2 latency on configurable line 0
        wr(A_RSEL, 32'h1);
        lines[0] = 1'b1;
        step(2);
        rdchk("R2 not before third edge", A_RP, 0);
        step(1);
        rdchk("R2 set at third edge", A_RP, 32'h1);
        lines[0] = 1'b0;
        step(3);
        wr(A_RP, 32'h1);
        wr(A_RSEL, 0);

        // R9 latency on direct line 6
        lines[6] = 1'b1;
        step(1);
        check("R9 direct before second edge", 32'(irq), 0);
        step(1);
        check("R9 direct after second edge", 32'(irq), 32'h40);
        lines[6] = 1'b0;
        step(2);
        check("R9 direct low again", 32'(irq), 0);

        // R5 event and clear on the same edge
        wr(A_RSEL, 32'h02);
        wr(A_SW, 32'h02);
        lines[1] = 1'b1;
        step(2);
        wr(A_RP, 32'h02);
        rdchk("R5 event beats clear", A_RP, 32'h02);
        wr(A_RP, 32'h02);
        rdchk("R5 later clear works", A_RP, 0);
        lines[1] = 1'b0;
        step(3);
        wr(A_RSEL, 0);

        // R6 trigger register reads OR of both pending registers
        wr(A_FSEL, 32'h08);
        lines[3] = 1'b1;
        step(3);
        lines[3] = 1'b0;
        step(3);
        wr(A_SW, 32'h10);
        rdchk("R6 sw readback", A_SW, 32'h18);
        wr(A_RP, 32'hFF);
        wr(A_FP, 32'hFF);
        wr(A_FSEL, 0);

        // sweep: every line, every select mode, full rise/fall cycle
        for (int ln = 0; ln < NL; ln++) begin
            for (int mode = 0; mode < 4; mode++) begin
                logic [31:0] bitv, er, ef;
                bit cfg;
                bitv = 32'h1 << ln;
                cfg  = CAP[ln];
                wr(A_RSEL, mode[0] ? bitv : 32'h0);
                wr(A_FSEL, mode[1] ? bitv : 32'h0);
                er = (cfg && mode[0]) ? bitv : 32'h0;
                ef = (cfg && mode[1]) ? bitv : 32'h0;
                lines[ln] = 1'b1;
                step(3);
                rdchk("R2 sweep rise", A_RP, er);
                rdchk("R3 sweep no fall on rise", A_FP, 0);
                check(cfg ? "R7 sweep irq high phase" : "R9 sweep irq high phase",
                      32'(irq), cfg ? er : bitv);
                lines[ln] = 1'b0;
                step(3);
                rdchk("R3 sweep fall", A_FP, ef);
                rdchk("R2 sweep rise held", A_RP, er);
                check(cfg ? "R7 sweep irq low phase" : "R9 sweep irq low phase",
                      32'(irq), er | ef);
                wr(A_RP, 32'hFF);
                wr(A_FP, 32'hFF);
                check("R4 sweep cleared", 32'(irq), 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule